// File: doc/BRIEF.md
# Prefixed Shift, Rotate and Bit Unit

This purely combinational unit executes the second-page instructions of an 8-bit processor core. These are the shift, rotate, nibble-swap and single-bit operations that follow a prefix byte. The core decodes the prefix, fetches the operand and hands the unit the opcode byte, the operand value and the current carry flag. The unit returns the new operand value, a result-write strobe and the four flags Z, N, H and C. Each flag has its own write strobe, so the core updates only the flags that the instruction touches.

The operand index in the low opcode bits is passed straight through for the core's writeback path. Operand fetch and writeback stay outside the unit, including the memory-operand form. The data width is a parameter. At the default of 8 bits, the opcode is one byte.

Top module: `pfx_bit_unit`

## Requirements
- R1: The opcode splits into a group in bits 7:6 (00 shift/rotate, 01 bit test, 10 bit clear, 11 bit set), a sub-operation or bit index in bits 5:3, and an operand index in bits 2:0. The operand index appears unchanged on `reg_sel_o`.
- R2: In group 00, all four flag strobes and `result_we_o` are 1. N and H are 0, and Z is 1 exactly when the result is zero.
- R3: Sub-operation 0 rotates left circularly and sub-operation 1 rotates right circularly. C receives the bit that leaves the byte: old bit 7 for the left rotate and old bit 0 for the right rotate.
- R4: Sub-operation 2 rotates left through carry: bit 0 takes the incoming carry and C takes old bit 7. Sub-operation 3 rotates right through carry: bit 7 takes the incoming carry and C takes old bit 0.
- R5: Sub-operation 4 shifts left and fills bit 0 with zero, with C taking old bit 7. Sub-operation 5 shifts right and keeps bit 7 at its old value, with C taking old bit 0.
- R6: Sub-operation 6 exchanges the two 4-bit halves and clears C. Sub-operation 7 shifts right and fills bit 7 with zero, with C taking old bit 0.
- R7: Group 01 sets Z to the inverse of the operand bit picked by bits 5:3, sets H to 1 and N to 0. It raises the Z, N and H strobes only, with `c_we_o` and `result_we_o` at 0.
- R8: Group 10 clears and group 11 sets the operand bit picked by bits 5:3. All other bits are left as they were, `result_we_o` is 1 and no flag strobe is raised.
- R9: A flag whose strobe is low is driven 0. When `result_we_o` is low, `result_o` equals `operand_i`.
- R10: `carry_i` changes the outputs only for sub-operations 2 and 3 of group 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opcode_i | input | 8 | Prefixed opcode byte |
| operand_i | input | 8 | Operand value |
| carry_i | input | 1 | Current carry flag |
| result_o | output | 8 | New operand value |
| result_we_o | output | 1 | Write strobe for the result |
| reg_sel_o | output | 3 | Operand index, passed through |
| flag_z_o | output | 1 | New Z flag |
| flag_n_o | output | 1 | New N flag |
| flag_h_o | output | 1 | New H flag |
| flag_c_o | output | 1 | New C flag |
| z_we_o | output | 1 | Write strobe for Z |
| n_we_o | output | 1 | Write strobe for N |
| h_we_o | output | 1 | Write strobe for H |
| c_we_o | output | 1 | Write strobe for C |

## Verification
The bench sweeps every opcode against every operand value with both carry values, which reaches every corner case.

- **Right-shift fill.** If the arithmetic right shift filled bit 7 with zero, operands 0x80 to 0xFF would come out positive. If the logical shift filled bit 7 with the sign, the same operands would keep their top bit.
- **Carry source.** If a through-carry rotate and a circular rotate took their fill bit from the wrong source, the results would differ whenever the incoming carry and the outgoing bit disagree.
- **Flags on bit operations.** If bit test wrote C or the result, the core would corrupt state. If clear or set raised a flag strobe, flags would change where they must not.
- **Zero result.** A shift that leaves zero while C is 1 (0x80 shifted left, 0x01 shifted right) exposes a Z flag taken from the wrong value.

// File: rtl/pfx_bit_pkg.sv
package pfx_bit_pkg;

   typedef enum logic [1:0] {
      GRP_SHIFT = 2'b00,
      GRP_TEST  = 2'b01,
      GRP_CLR   = 2'b10,
      GRP_SET   = 2'b11
   } grp_e;

   // Order of the shift group sub-operations is part of the opcode encoding.
   typedef enum logic [2:0] {
      SH_ROL = 3'd0,
      SH_ROR = 3'd1,
      SH_RCL = 3'd2,
      SH_RCR = 3'd3,
      SH_ASL = 3'd4,
      SH_ASR = 3'd5,
      SH_SWP = 3'd6,
      SH_LSR = 3'd7
   } shop_e;

   typedef struct packed {
      logic z;
      logic n;
      logic h;
      logic c;
   } flags_t;

endpackage

// File: rtl/pfx_bit_decode.sv
module pfx_bit_decode
   import pfx_bit_pkg::*;
#(
   parameter int IDX_W = 3,
   parameter int REG_W = 3,
   localparam int OPC_W = 2 + IDX_W + REG_W
) (
   input  logic [OPC_W-1:0] opcode_i,
   output grp_e             grp_o,
   output logic [IDX_W-1:0] field_o,
   output logic [REG_W-1:0] reg_sel_o
);

   assign grp_o     = grp_e'(opcode_i[OPC_W-1 -: 2]);
   assign field_o   = opcode_i[REG_W +: IDX_W];
   assign reg_sel_o = opcode_i[REG_W-1:0];

endmodule

// File: rtl/pfx_bit_shift.sv
module pfx_bit_shift
   import pfx_bit_pkg::*;
#(
   parameter int W = 8,
   localparam int HALF = W / 2
) (
   input  logic [W-1:0] val_i,
   input  logic         cin_i,
   input  shop_e        op_i,
   output logic [W-1:0] res_o,
   output logic         cout_o
);

   logic top_b;
   logic bot_b;

   assign top_b = val_i[W-1];
   assign bot_b = val_i[0];

   always_comb begin
      res_o  = val_i;
      cout_o = 1'b0;
      unique case (op_i)
         SH_ROL: begin res_o = {val_i[W-2:0], top_b};  cout_o = top_b; end
         SH_ROR: begin res_o = {bot_b, val_i[W-1:1]};  cout_o = bot_b; end
         SH_RCL: begin res_o = {val_i[W-2:0], cin_i};  cout_o = top_b; end
         SH_RCR: begin res_o = {cin_i, val_i[W-1:1]};  cout_o = bot_b; end
         SH_ASL: begin res_o = {val_i[W-2:0], 1'b0};   cout_o = top_b; end
         SH_ASR: begin res_o = {top_b, val_i[W-1:1]};  cout_o = bot_b; end
         SH_SWP: begin res_o = {val_i[HALF-1:0], val_i[W-1:HALF]}; cout_o = 1'b0; end
         SH_LSR: begin res_o = {1'b0, val_i[W-1:1]};   cout_o = bot_b; end
         default: begin res_o = val_i; cout_o = 1'b0; end
      endcase
   end

endmodule

// File: rtl/pfx_bit_mod.sv
module pfx_bit_mod #(
   parameter int W = 8,
   localparam int IDX_W = $clog2(W)
) (
   input  logic [W-1:0]     val_i,
   input  logic [IDX_W-1:0] idx_i,
   output logic             bit_o,
   output logic [W-1:0]     clr_o,
   output logic [W-1:0]     set_o
);

   logic [W-1:0] mask;

   // One comparator per bit position builds the one-hot select mask.
   for (genvar gi = 0; gi < W; gi++) begin : g_mask
      assign mask[gi] = (idx_i == IDX_W'(gi));
   end

   assign bit_o = |(val_i & mask);
   assign clr_o = val_i & ~mask;
   assign set_o = val_i | mask;

endmodule

// File: rtl/pfx_bit_unit.sv
module pfx_bit_unit
   import pfx_bit_pkg::*;
#(
   parameter int W = 8,
   parameter int REG_W = 3,
   localparam int IDX_W = $clog2(W),
   localparam int OPC_W = 2 + IDX_W + REG_W
) (
   input  logic [OPC_W-1:0] opcode_i,
   input  logic [W-1:0]     operand_i,
   input  logic             carry_i,
   output logic [W-1:0]     result_o,
   output logic             result_we_o,
   output logic [REG_W-1:0] reg_sel_o,
   output logic             flag_z_o,
   output logic             flag_n_o,
   output logic             flag_h_o,
   output logic             flag_c_o,
   output logic             z_we_o,
   output logic             n_we_o,
   output logic             h_we_o,
   output logic             c_we_o
);

   if (W < 8 || (W & (W - 1)) != 0) begin : g_bad_w
      $error("pfx_bit_unit: W must be a power of two of at least 8");
   end
   if (REG_W < 1) begin : g_bad_reg
      $error("pfx_bit_unit: REG_W must be at least 1");
   end

   grp_e             grp;
   logic [IDX_W-1:0] field;
   logic [W-1:0]     sh_res;
   logic             sh_c;
   logic             sel_bit;
   logic [W-1:0]     clr_val;
   logic [W-1:0]     set_val;
   flags_t           flg;
   flags_t           flg_we;

   pfx_bit_decode #(.IDX_W(IDX_W), .REG_W(REG_W)) u_dec (
      .opcode_i  (opcode_i),
      .grp_o     (grp),
      .field_o   (field),
      .reg_sel_o (reg_sel_o)
   );

   // The shift group decodes the low three bits of the field.
   pfx_bit_shift #(.W(W)) u_shift (
      .val_i  (operand_i),
      .cin_i  (carry_i),
      .op_i   (shop_e'(field[2:0])),
      .res_o  (sh_res),
      .cout_o (sh_c)
   );

   pfx_bit_mod #(.W(W)) u_bit (
      .val_i (operand_i),
      .idx_i (field),
      .bit_o (sel_bit),
      .clr_o (clr_val),
      .set_o (set_val)
   );

   always_comb begin
      result_o    = operand_i;
      result_we_o = 1'b0;
      flg         = '0;
      flg_we      = '0;
      unique case (grp)
         GRP_SHIFT: begin
            result_o    = sh_res;
            result_we_o = 1'b1;
            flg.z       = ~|sh_res;
            flg.c       = sh_c;
            flg_we      = 4'b1111;
         end
         GRP_TEST: begin
            flg.z  = ~sel_bit;
            flg.h  = 1'b1;
            flg_we = 4'b1110;
         end
         GRP_CLR: begin
            result_o    = clr_val;
            result_we_o = 1'b1;
         end
         GRP_SET: begin
            result_o    = set_val;
            result_we_o = 1'b1;
         end
         default: begin
            result_o    = operand_i;
            result_we_o = 1'b0;
         end
      endcase
   end

   assign flag_z_o = flg.z;
   assign flag_n_o = flg.n;
   assign flag_h_o = flg.h;
   assign flag_c_o = flg.c;
   assign z_we_o   = flg_we.z;
   assign n_we_o   = flg_we.n;
   assign h_we_o   = flg_we.h;
   assign c_we_o   = flg_we.c;

endmodule

// File: rtl/pfx_bit_unit_chk.sv
module pfx_bit_unit_chk #(
   parameter int W = 8,
   parameter int REG_W = 3,
   localparam int IDX_W = $clog2(W),
   localparam int OPC_W = 2 + IDX_W + REG_W
) (
   input logic [OPC_W-1:0] opcode_i,
   input logic [W-1:0]     operand_i,
   input logic [W-1:0]     result_o,
   input logic             result_we_o,
   input logic             flag_z_o,
   input logic             flag_n_o,
   input logic             flag_h_o,
   input logic             flag_c_o,
   input logic             z_we_o,
   input logic             n_we_o,
   input logic             h_we_o,
   input logic             c_we_o
);

   logic [1:0] grp;
   logic [2:0] sub;
   logic       known;

   assign grp   = opcode_i[OPC_W-1 -: 2];
   assign sub   = opcode_i[REG_W +: 3];
   assign known = !$isunknown({opcode_i, operand_i, result_o, result_we_o,
                               flag_z_o, flag_n_o, flag_h_o, flag_c_o,
                               z_we_o, n_we_o, h_we_o, c_we_o});

   always_comb begin
      if (known) begin
         if (grp == 2'b00) begin
            AST_SHIFT_FLAGS: assert (z_we_o && n_we_o && h_we_o && c_we_o && result_we_o
                                     && !flag_n_o && !flag_h_o
                                     && (flag_z_o == (result_o == '0)))
               else $error("shift group flag handling wrong"); // R2
         end
         if (grp == 2'b00 && sub == 3'd6) begin
            AST_SWAP_CLR_C: assert (!flag_c_o && ($countones(result_o) == $countones(operand_i)))
               else $error("swap must clear C and keep bit count"); // R6
         end
         if (grp == 2'b01) begin
            AST_TEST_NO_WRITE: assert (!result_we_o && !c_we_o && flag_h_o && !flag_n_o
                                       && result_o == operand_i)
               else $error("bit test wrote result or carry"); // R7
         end
         if (grp[1]) begin
            AST_BITOP_NO_FLAGS: assert (result_we_o && !z_we_o && !n_we_o && !h_we_o && !c_we_o)
               else $error("bit clear/set touched flags"); // R8
            AST_BITOP_ONE_BIT: assert ($countones(result_o ^ operand_i) <= 1)
               else $error("bit clear/set changed more than one bit"); // R8
         end
         AST_IDLE_FLAGS_LOW: assert ((z_we_o || !flag_z_o) && (n_we_o || !flag_n_o)
                                     && (h_we_o || !flag_h_o) && (c_we_o || !flag_c_o))
            else $error("flag driven without its strobe"); // R9
      end
   end

endmodule

bind pfx_bit_unit pfx_bit_unit_chk #(.W(W), .REG_W(REG_W)) u_chk (
   .opcode_i    (opcode_i),
   .operand_i   (operand_i),
   .result_o    (result_o),
   .result_we_o (result_we_o),
   .flag_z_o    (flag_z_o),
   .flag_n_o    (flag_n_o),
   .flag_h_o    (flag_h_o),
   .flag_c_o    (flag_c_o),
   .z_we_o      (z_we_o),
   .n_we_o      (n_we_o),
   .h_we_o      (h_we_o),
   .c_we_o      (c_we_o)
);

// File: tb/sim_pfx_bit_unit.sv
`timescale 1ns/1ps
module sim_pfx_bit_unit;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [7:0] opcode;
   logic [7:0] operand;
   logic       carry;
   logic [7:0] result;
   logic       result_we;
   logic [2:0] reg_sel;
   logic       fz, fn, fh, fc;
   logic       zwe, nwe, hwe, cwe;

   int n_run  = 0;
   int n_fail = 0;
   int cycles = 0;
   bit done   = 1'b0;

   always #10 clk = ~clk; // 50 MHz

   pfx_bit_unit u0 (
      .opcode_i    (opcode),
      .operand_i   (operand),
      .carry_i     (carry),
      .result_o    (result),
      .result_we_o (result_we),
      .reg_sel_o   (reg_sel),
      .flag_z_o    (fz),
      .flag_n_o    (fn),
      .flag_h_o    (fh),
      .flag_c_o    (fc),
      .z_we_o      (zwe),
      .n_we_o      (nwe),
      .h_we_o      (hwe),
      .c_we_o      (cwe)
   );

   // Packed view: {result, result_we, z, n, h, c, zwe, nwe, hwe, cwe, reg_sel}
   function automatic logic [19:0] model(int o, int v, int c);
      int g = o / 64;
      int f = (o / 8) % 8;
      int r = v;
      int rwe = 0, z = 0, n = 0, h = 0, cf = 0, we = 0;
      if (g == 0) begin
         // R2: all strobes, N=H=0, Z from result
         rwe = 1; we = 15;
         case (f)
            0: begin r = (v * 2) % 256 + v / 128; cf = v / 128; end   // R3
            1: begin r = v / 2 + (v % 2) * 128;   cf = v % 2;   end   // R3
            2: begin r = (v * 2) % 256 + c;       cf = v / 128; end   // R4, R10
            3: begin r = v / 2 + c * 128;         cf = v % 2;   end   // R4, R10
            4: begin r = (v * 2) % 256;           cf = v / 128; end   // R5
            5: begin r = v / 2 + (v / 128) * 128; cf = v % 2;   end   // R5
            6: begin r = (v % 16) * 16 + v / 16;  cf = 0;       end   // R6
            default: begin r = v / 2;             cf = v % 2;   end   // R6
         endcase
         z = (r == 0) ? 1 : 0;
      end else if (g == 1) begin
         z = (((v >> f) % 2) == 0) ? 1 : 0; h = 1; we = 14;          // R7
      end else if (g == 2) begin
         r = v - (((v >> f) % 2) << f); rwe = 1;                      // R8
      end else begin
         r = v + ((1 - ((v >> f) % 2)) << f); rwe = 1;                // R8
      end
      // R1: operand index is the low three opcode bits; R9: unwritten flags 0
      return {8'(r), 1'(rwe), 1'(z), 1'(n), 1'(h), 1'(cf), 4'(we), 3'(o % 8)};
   endfunction

   function automatic string tag_of(int o);
      int g = o / 64;
      int f = (o / 8) % 8;
      if (g == 1) return "R7";
      if (g >= 2) return "R8";
      if (f < 2) return "R3";
      if (f < 4) return "R4";
      if (f < 6) return "R5";
      return "R6";
   endfunction

   task automatic check(string tag, logic [19:0] exp);
      logic [19:0] act;
      act = {result, result_we, fz, fn, fh, fc, zwe, nwe, hwe, cwe, reg_sel};
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s op=%02h val=%02h cin=%0d actual=%05h expected=%05h",
                  tag, opcode, operand, carry, act, exp);
      end
   endtask

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles > 190000 && !done) begin
         n_fail++;
         $display("FAIL watchdog expired");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      opcode = 8'h00; operand = 8'h00; carry = 1'b0;
      #25 rst = 1'b0;
      // Initial state: rotate of zero gives Z=1, C=0 (R2, R3)
      #5 check("R2", model(0, 0, 0));
      // Sweep every opcode, operand and carry (R1 R2 R9 R10 checked in every vector)
      for (int o = 0; o < 256; o++) begin
         for (int v = 0; v < 256; v++) begin
            for (int c = 0; c < 2; c++) begin
               opcode = 8'(o); operand = 8'(v); carry = 1'(c);
               #5 check(tag_of(o), model(o, v, c));
               #5;
            end
         end
      end
      // Directed zero-result corners with C set (R5, R6)
      opcode = 8'h20; operand = 8'h80; carry = 1'b0;
      #5 check("R5", {8'h00, 1'b1, 4'b1001, 4'hF, 3'd0});
      #5 opcode = 8'h3D; operand = 8'h01; carry = 1'b1;
      #5 check("R6", {8'h00, 1'b1, 4'b1001, 4'hF, 3'd5});
      #5 opcode = 8'h36; operand = 8'hA5; carry = 1'b1;
      #5 check("R6", {8'h5A, 1'b1, 4'b0000, 4'hF, 3'd6});
      #5 done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule